// File: doc/BRIEF.md
# Serial-to-Parallel Bus Bridge

This block lets a small controller with only a handful of spare pins operate a parallel memory-style bus: a 16-bit address bus and an 8-bit bidirectional data bus. The controller clocks a write frame into a 24-bit shift chain over a serial data pin and a serial clock pin. A pulse on a latch strobe then moves the frame into three holding registers: address high, address low and outgoing data. Two active-low enables, one per bus, decide when the address bus and the data bus are driven. On the chip these become the drive enables of the pad cells, so no tri-state net exists inside the block.

For reads, the controller pulses a capture strobe. This samples the data bus into a read register whose top bit appears on the serial output at once. Each later serial clock pulse moves the next bit out. All pins are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and edges are found in the system clock domain, so every action takes effect on the third system clock edge after the pin changes.

Top module: `sbb_bridge`

## Requirements
- R1: While reset is asserted, and on the edge where it is released, the address and data outputs are zero, both drive enables are low, and the serial output is low.
- R2: Each rising edge of the serial clock, a transition from 0 to 1, shifts the serial data pin into the chain. Bytes are sent most-significant bit first in the order data byte, address bits 7:0, address bits 15:8. After 24 shifts and a latch, data_o holds the first byte and addr_o holds {third byte, second byte}.
- R3: The latch strobe acts on its return high, the 0 to 1 transition. While it is held low, the outputs keep their old values.
- R4: addr_o and data_o change only after a latch strobe. Shifting a whole new frame without a latch leaves them unchanged.
- R5: addr_oe_o is the inverse of the synchronised addr_en_n_i, and data_oe_o is the inverse of the synchronised data_en_n_i. The two are independent, and each follows its pin two system clock edges after the pin changes.
- R6: The return high of the capture strobe loads data_i into the read register, and bit 7 of the loaded value appears on ser_dat_o at once.
- R7: Each rising serial clock edge after a capture shifts the read register by one bit toward the output, filling with zeros. After eight edges, ser_dat_o is low.
- R8: A serial clock, latch or capture transition on a pin takes effect on the third system clock edge after the pin change, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock, idles high |
| ser_dat_i | input | 1 | Serial write data, changed while ser_clk_i is low |
| latch_n_i | input | 1 | Output latch strobe, pulsed low |
| capture_n_i | input | 1 | Data bus capture strobe, pulsed low |
| addr_en_n_i | input | 1 | Address bus enable, active low |
| data_en_n_i | input | 1 | Data bus enable, active low |
| data_i | input | 8 | Data bus value seen at the pads |
| addr_o | output | 16 | Address holding register to the pads |
| addr_oe_o | output | 1 | Address pad drive enable, active high |
| data_o | output | 8 | Outgoing data holding register to the pads |
| data_oe_o | output | 1 | Data pad drive enable, active high |
| ser_dat_o | output | 1 | Serial read data |

## Verification
The assertions take for granted that the host holds each pin level for at least three system clocks. This applies to the serial data bit around a serial clock rise and to data_i around the end of a capture pulse. They also assume that a latch or capture never coincides with a serial clock rise, and that every pin sits at its idle level while reset is applied. The stimulus holds each pin phase for four system clocks and keeps the strobes apart from serial clock activity. A reference model that delays each pin by whole cycles is compared with every output on every clock.

// File: rtl/sbb_pkg.sv
package sbb_pkg;

   // Edge-detected strobes, bit positions inside the edge bank
   localparam int unsigned EV_SCLK  = 0;
   localparam int unsigned EV_LATCH = 1;
   localparam int unsigned EV_CAPT  = 2;
   localparam int unsigned N_EV     = 3;

   // Level-synchronised pins, bit positions inside the level bank
   localparam int unsigned LV_SDAT  = 0;
   localparam int unsigned LV_AEN   = 1;
   localparam int unsigned LV_DEN   = 2;
   localparam int unsigned N_LV     = 3;

   // Idle values held by the synchronisers during reset
   localparam logic [N_EV-1:0] EV_IDLE = 3'b111;
   localparam logic [N_LV-1:0] LV_IDLE = 3'b110;

   typedef struct packed {
      logic capt;
      logic latch;
      logic sclk;
   } sbb_evt_t;

endpackage

// File: rtl/sbb_sync.sv
module sbb_sync #(
   parameter int unsigned     WIDTH  = 3,
   parameter int unsigned     STAGES = 2,
   parameter bit              EDGE   = 1'b0,
   parameter logic [WIDTH-1:0] IDLE  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] ev_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sbb_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sbb_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= IDLE;
      else        stage_q[0] <= pin_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= IDLE;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   if (EDGE) begin : g_edge
      logic [WIDTH-1:0] prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= IDLE;
         else        prev_q <= stage_q[STAGES-1];
      end
      assign ev_o = stage_q[STAGES-1] & ~prev_q;
   end else begin : g_level
      assign ev_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/sbb_wr_path.sv
module sbb_wr_path #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   input  logic              latch_en,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int unsigned CHAIN_W = DATA_W + ADDR_W;
   localparam int unsigned HALF_W  = ADDR_W / 2;

   if ((ADDR_W % 2) != 0) begin : g_bad_addr
      $error("sbb_wr_path: ADDR_W must be even");
   end

   logic [CHAIN_W-1:0] chain_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [DATA_W-1:0]  data_q;

   // First-sent field ends up at the top of the chain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        chain_q <= '0;
      else if (shift_en) chain_q <= {chain_q[CHAIN_W-2:0], bit_in};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (latch_en) begin
         data_q <= chain_q[CHAIN_W-1 -: DATA_W];
         addr_q <= {chain_q[HALF_W-1:0], chain_q[ADDR_W-1 -: HALF_W]};
      end
   end

   assign addr_o = addr_q;
   assign data_o = data_q;

endmodule

// File: rtl/sbb_rd_path.sv
module sbb_rd_path #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [DATA_W-1:0] load_val,
   input  logic              step_en,
   output logic              ser_o
);

   if (DATA_W < 2) begin : g_bad_data
      $error("sbb_rd_path: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] sh_q;

   // A capture wins over a shift in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (load_en) sh_q <= load_val;
      else if (step_en) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
   end

   assign ser_o = sh_q[DATA_W-1];

endmodule

// File: rtl/sbb_bridge.sv
module sbb_bridge #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_dat_i,
   input  logic              latch_n_i,
   input  logic              capture_n_i,
   input  logic              addr_en_n_i,
   input  logic              data_en_n_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_oe_o,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe_o,
   output logic              ser_dat_o
);

   import sbb_pkg::*;

   logic [N_EV-1:0] ev_pins;
   logic [N_EV-1:0] ev_rise;
   logic [N_LV-1:0] lv_pins;
   logic [N_LV-1:0] lv_sync;
   sbb_evt_t        evt;

   assign ev_pins[EV_SCLK]  = ser_clk_i;
   assign ev_pins[EV_LATCH] = latch_n_i;
   assign ev_pins[EV_CAPT]  = capture_n_i;

   assign lv_pins[LV_SDAT]  = ser_dat_i;
   assign lv_pins[LV_AEN]   = addr_en_n_i;
   assign lv_pins[LV_DEN]   = data_en_n_i;

   sbb_sync #(
      .WIDTH (N_EV),
      .STAGES(STAGES),
      .EDGE  (1'b1),
      .IDLE  (EV_IDLE)
   ) u_ev_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_i(ev_pins),
      .ev_o (ev_rise)
   );

   sbb_sync #(
      .WIDTH (N_LV),
      .STAGES(STAGES),
      .EDGE  (1'b0),
      .IDLE  (LV_IDLE)
   ) u_lv_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_i(lv_pins),
      .ev_o (lv_sync)
   );

   assign evt.sclk  = ev_rise[EV_SCLK];
   assign evt.latch = ev_rise[EV_LATCH];
   assign evt.capt  = ev_rise[EV_CAPT];

   sbb_wr_path #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(evt.sclk),
      .bit_in  (lv_sync[LV_SDAT]),
      .latch_en(evt.latch),
      .addr_o  (addr_o),
      .data_o  (data_o)
   );

   sbb_rd_path #(
      .DATA_W(DATA_W)
   ) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (evt.capt),
      .load_val(data_i),
      .step_en (evt.sclk),
      .ser_o   (ser_dat_o)
   );

   assign addr_oe_o = ~lv_sync[LV_AEN];
   assign data_oe_o = ~lv_sync[LV_DEN];

endmodule

// File: rtl/sbb_bridge_chk.sv
module sbb_bridge_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ser_clk_i,
   input logic              latch_n_i,
   input logic              capture_n_i,
   input logic              addr_en_n_i,
   input logic              data_en_n_i,
   input logic              data_msb_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic [DATA_W-1:0] data_o,
   input logic              addr_oe_o,
   input logic              data_oe_o,
   input logic              ser_dat_o
);

   p_reset_state_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (addr_o == '0 && data_o == '0 && !addr_oe_o && !data_oe_o && !ser_dat_o))
      else $error("p_reset_state_r1");

   // The pin-delay windows below assume the default two-stage synchroniser
   if (STAGES == 2) begin : g_two_stage
      p_latch_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable({addr_o, data_o}) |-> ($past(latch_n_i, 3) && !$past(latch_n_i, 4)))
         else $error("p_latch_only_r4");

      p_addr_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
         addr_oe_o == !$past(addr_en_n_i, 2))
         else $error("p_addr_oe_r5");

      p_data_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
         data_oe_o == !$past(data_en_n_i, 2))
         else $error("p_data_oe_r5");

      p_capture_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(capture_n_i, 3) && !$past(capture_n_i, 4)) |-> (ser_dat_o == $past(data_msb_i)))
         else $error("p_capture_load_r6");

      p_ser_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(ser_dat_o) |->
            (($past(ser_clk_i, 3) && !$past(ser_clk_i, 4)) ||
             ($past(capture_n_i, 3) && !$past(capture_n_i, 4))))
         else $error("p_ser_hold_r7");
   end

endmodule

bind sbb_bridge sbb_bridge_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .STAGES(STAGES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ser_clk_i  (ser_clk_i),
   .latch_n_i  (latch_n_i),
   .capture_n_i(capture_n_i),
   .addr_en_n_i(addr_en_n_i),
   .data_en_n_i(data_en_n_i),
   .data_msb_i (data_i[DATA_W-1]),
   .addr_o     (addr_o),
   .data_o     (data_o),
   .addr_oe_o  (addr_oe_o),
   .data_oe_o  (data_oe_o),
   .ser_dat_o  (ser_dat_o)
);

// File: tb/sbb_bridge_tb_top.sv
module sbb_bridge_tb_top;

   localparam int AW   = 16;
   localparam int DW   = 8;
   localparam int HOLD = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ser_clk = 1'b1;
   logic          ser_dat = 1'b0;
   logic          latch_n = 1'b1;
   logic          capt_n = 1'b1;
   logic          aen_n = 1'b1;
   logic          den_n = 1'b1;
   logic [DW-1:0] data_in = '0;
   logic [AW-1:0] addr_o;
   logic [DW-1:0] data_o;
   logic          addr_oe_o;
   logic          data_oe_o;
   logic          ser_dat_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   bit started = 1'b0;

   always #(10ns) clk = ~clk;

   sbb_bridge dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_clk_i  (ser_clk),
      .ser_dat_i  (ser_dat),
      .latch_n_i  (latch_n),
      .capture_n_i(capt_n),
      .addr_en_n_i(aen_n),
      .data_en_n_i(den_n),
      .data_i     (data_in),
      .addr_o     (addr_o),
      .addr_oe_o  (addr_oe_o),
      .data_o     (data_o),
      .data_oe_o  (data_oe_o),
      .ser_dat_o  (ser_dat_o)
   );

   task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Reference model: each pin seen through whole-cycle delays
   logic [3:0]      h_sclk, h_sdat, h_latch, h_capt, h_aen, h_den;
   logic [AW+DW-1:0] m_chain;
   logic [AW-1:0]   m_addr;
   logic [DW-1:0]   m_data;
   logic [DW-1:0]   m_rd;
   logic            m_aoe, m_doe;

   always @(posedge clk) begin
      if (!rst_n) begin
         h_sclk = '1; h_sdat = '0; h_latch = '1; h_capt = '1; h_aen = '1; h_den = '1;
         m_chain = '0; m_addr = '0; m_data = '0; m_rd = '0; m_aoe = 1'b0; m_doe = 1'b0;
      end else begin
         h_sclk  = {h_sclk[2:0],  ser_clk};
         h_sdat  = {h_sdat[2:0],  ser_dat};
         h_latch = {h_latch[2:0], latch_n};
         h_capt  = {h_capt[2:0],  capt_n};
         h_aen   = {h_aen[2:0],   aen_n};
         h_den   = {h_den[2:0],   den_n};
         if (h_latch[2] && !h_latch[3]) begin
            m_data = m_chain[23:16];
            m_addr = {m_chain[7:0], m_chain[15:8]};
         end
         if (h_capt[2] && !h_capt[3]) m_rd = data_in;
         else if (h_sclk[2] && !h_sclk[3]) m_rd = m_rd << 1;
         if (h_sclk[2] && !h_sclk[3]) m_chain = {m_chain[22:0], h_sdat[2]};
         m_aoe = !h_aen[1];
         m_doe = !h_den[1];
      end
      started = 1'b1;
   end

   always @(negedge clk) begin
      if (started && !done) begin
         check_val("R2/R4 addr_o", addr_o, m_addr);
         check_val("R2/R4 data_o", data_o, m_data);
         check_val("R5 addr_oe_o", addr_oe_o, m_aoe);
         check_val("R5 data_oe_o", data_oe_o, m_doe);
         check_val("R6/R7 ser_dat_o", ser_dat_o, m_rd[DW-1]);
      end
   end

   // Host-side tasks, entered at a falling clock edge
   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         ser_clk = 1'b0;
         ser_dat = b[i];
         repeat (HOLD) @(negedge clk);
         ser_clk = 1'b1;
         repeat (HOLD) @(negedge clk);
      end
   endtask

   task automatic send_frame(input logic [7:0] d, input logic [7:0] lo, input logic [7:0] hi);
      send_byte(d);
      send_byte(lo);
      send_byte(hi);
   endtask

   task automatic latch_pulse();
      latch_n = 1'b0;
      repeat (HOLD) @(negedge clk);
      latch_n = 1'b1;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic capture(input logic [7:0] v);
      data_in = v;
      capt_n = 1'b0;
      repeat (HOLD) @(negedge clk);
      capt_n = 1'b1;
      repeat (HOLD) @(negedge clk);
   endtask

   task automatic read_byte(output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         b[i] = ser_dat_o;
         ser_clk = 1'b0;
         repeat (HOLD) @(negedge clk);
         ser_clk = 1'b1;
         repeat (HOLD) @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] rb;
      repeat (5) @(negedge clk);
      // R1: reset values
      check_val("R1 addr_o", addr_o, 0);
      check_val("R1 data_o", data_o, 0);
      check_val("R1 oe", {addr_oe_o, data_oe_o}, 0);
      check_val("R1 ser_dat_o", ser_dat_o, 0);
      rst_n = 1'b1;
      repeat (HOLD) @(negedge clk);

      // R2/R3/R8: first frame
      send_frame(8'hA5, 8'h3C, 8'h81);
      check_val("R4 no latch yet addr_o", addr_o, 0);
      latch_n = 1'b0;
      repeat (HOLD) @(negedge clk);
      check_val("R3 strobe low data_o", data_o, 0);
      latch_n = 1'b1;
      repeat (2) @(negedge clk);
      check_val("R8 second edge data_o", data_o, 0);
      @(negedge clk);
      check_val("R8 third edge data_o", data_o, 8'hA5);
      check_val("R2 data_o", data_o, 8'hA5);
      check_val("R2 addr_o", addr_o, 16'h813C);
      repeat (HOLD) @(negedge clk);

      // R5: enables independent
      aen_n = 1'b0;
      repeat (HOLD) @(negedge clk);
      check_val("R5 addr only", {addr_oe_o, data_oe_o}, 2'b10);
      den_n = 1'b0;
      repeat (HOLD) @(negedge clk);
      check_val("R5 both", {addr_oe_o, data_oe_o}, 2'b11);
      aen_n = 1'b1;
      repeat (HOLD) @(negedge clk);
      check_val("R5 data only", {addr_oe_o, data_oe_o}, 2'b01);
      den_n = 1'b1;
      repeat (HOLD) @(negedge clk);

      // R4: new frame without latch leaves outputs
      send_frame(8'h11, 8'h22, 8'h33);
      check_val("R4 addr_o held", addr_o, 16'h813C);
      check_val("R4 data_o held", data_o, 8'hA5);
      latch_pulse();
      check_val("R2 second frame addr_o", addr_o, 16'h3322);
      check_val("R2 second frame data_o", data_o, 8'h11);

      send_frame(8'hFF, 8'h00, 8'hFF);
      latch_pulse();
      check_val("R2 edge pattern addr_o", addr_o, 16'hFF00);
      check_val("R2 edge pattern data_o", data_o, 8'hFF);

      // R6/R7: readback
      capture(8'hC6);
      check_val("R6 msb preload", ser_dat_o, 1);
      read_byte(rb);
      check_val("R7 readback C6", rb, 8'hC6);
      check_val("R7 drained", ser_dat_o, 0);
      check_val("R4 readback leaves addr_o", addr_o, 16'hFF00);

      capture(8'h01);
      check_val("R6 msb preload zero", ser_dat_o, 0);
      read_byte(rb);
      check_val("R7 readback 01", rb, 8'h01);
      check_val("R7 drained after 01", ser_dat_o, 0);

      repeat (HOLD) @(negedge clk);
      finish_run();
   end

endmodule